// File: doc/BRIEF.md
# Byte-wide ALU with selective status flags

This block is the arithmetic and logic stage of a small RISC core. Each cycle it takes two byte operands, an incoming carry, the current zero flag and a 5-bit operation code. It returns a one-byte result, a six-bit flag vector, a mask of the flags the operation is allowed to change, and a write strobe that says whether the result belongs in the destination register. The core keeps the status register itself and merges the flags through the mask. Every output is registered, so results appear one clock after the operands are presented.

The operations cover add and subtract with and without carry, compare with and without carry, AND, OR, XOR, one's and two's complement, increment, decrement, left shift, rotate left and right through carry, logical and arithmetic right shift, and nibble swap. Each operation updates its own subset of flags. The carry-chained subtract and compare keep the zero flag set only if it was set on the way in, so a compare across several bytes reports equality correctly.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, every output reads 0 after that edge. Otherwise each output reflects the inputs sampled at the previous rising edge. Flag and mask bit order is H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: Add (op 0) and add-with-carry (op 1, adds `c_i`) give a+b(+c). C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. All six flags are in the mask.
- R3: Subtract (op 2), subtract-with-carry (op 3, subtracts `c_i`) and negate (op 10, 0x00-a) set C when the operation borrows out of bit 7 and H when it borrows into bit 4. V is signed overflow. All six flags are in the mask and the result is written.
- R4: Compare (op 4) and compare-with-carry (op 5) produce the same flags as op 2 and op 3, with all six flags in the mask, but hold `wr_o` low.
- R5: For ops 3 and 5, Z is 1 only when the result is zero and `z_i` is 1. All other ops ignore `z_i`.
- R6: AND (op 6), OR (op 7) and XOR (op 8) give mask 0x1E (S,V,N,Z) with V=0.
- R7: One's complement (op 9) gives 0xFF-a with C=1 and V=0, mask 0x1F.
- R8: Increment (op 11) and decrement (op 12) give a+1 and a-1, mask 0x1E. V is 1 only for inputs 0x7F and 0x80 respectively.
- R9: Shift left (op 13, inserts 0) and rotate left (op 14, inserts `c_i` into bit 0) set C from bit 7, H from bit 3 and V=N^C, with all six flags in the mask.
- R10: Logical right shift (op 15, inserts 0), rotate right (op 16, inserts `c_i` into bit 7) and arithmetic right shift (op 17, keeps bit 7) set C from bit 0 and V=N^C, mask 0x1F.
- R11: Swap (op 18) exchanges the nibbles of a, with mask 0 and all flags 0.
- R12: N is result bit 7 and S equals N XOR V whenever S is in the mask. Flag bits outside the mask read 0.
- R13: Codes 19 to 31 give result 0, mask 0 and `wr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination register) |
| b_i | input | 8 | Second operand (register or immediate) |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag for chained ops |
| res_o | output | 8 | Result |
| flags_o | output | 6 | H,S,V,N,Z,C, bits outside mask zero |
| upd_o | output | 6 | Mask of flags this op changes |
| wr_o | output | 1 | Result is to be written |

## Verification
The block keeps no state beyond its output register. A wrong decode or flag equation therefore shows up on the ports exactly one cycle after the faulty operand set, and it can be seen either as a wrong flag value or as a mask that lets a flag through when it should not. The corner cases that need their own vectors are the signed-overflow edges (0x7F, 0x80), half-carry boundaries, borrow with carry-in, and the zero-chain for carry-based compares with `z_i` both set and clear. Random operands across all codes, including the unused ones, cover the rest.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 5;
  localparam int FLW = 6;
  localparam int FH = 5, FS = 4, FV = 3, FN = 2, FZ = 1, FC = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_ROL = 5'd14, OP_LSR = 5'd15,
    OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18
  } alu_op_e;

  localparam logic [FLW-1:0] M_ALL = 6'b111111;
  localparam logic [FLW-1:0] M_SVNZ = 6'b011110;
  localparam logic [FLW-1:0] M_SVNZC = 6'b011111;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c,
  output logic         h,
  output logic         v
);
  localparam int HB = W / 2 - 1;
  logic [W:0] wide;
  logic xs, ys, rs, xh, yh, rh;

  always_comb begin
    if (sub) wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
    else     wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    r  = wide[W-1:0];
    c  = wide[W];
    xs = x[W-1]; ys = y[W-1]; rs = r[W-1];
    xh = x[HB];  yh = y[HB];  rh = r[HB];
    if (sub) begin
      h = (~xh & yh) | (yh & rh) | (rh & ~xh);
      v = (xs & ~ys & ~rs) | (~xs & ys & rs);
    end else begin
      h = (xh & yh) | (yh & ~rh) | (~rh & xh);
      v = (xs & ys & ~rs) | (~xs & ~ys & rs);
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         c,
  output logic         v
);
  localparam int HW = W / 2;

  always_comb begin
    r = '0;
    c = 1'b0;
    v = 1'b0;
    case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_COM: begin r = ~a; c = 1'b1; end
      OP_LSR: begin r = {1'b0, a[W-1:1]};   c = a[0]; end
      OP_ROR: begin r = {cin, a[W-1:1]};    c = a[0]; end
      OP_ASR: begin r = {a[W-1], a[W-1:1]}; c = a[0]; end
      OP_SWP: r = {a[HW-1:0], a[W-1:HW]};
      default: r = '0;
    endcase
    if (op == OP_LSR || op == OP_ROR || op == OP_ASR) v = r[W-1] ^ c;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_i,
  input  logic           z_i,
  output logic [W-1:0]   res_o,
  output logic [FLW-1:0] flags_o,
  output logic [FLW-1:0] upd_o,
  output logic           wr_o
);
  alu_op_e        op;
  logic [W-1:0]   ax, ay, ar, lr, r;
  logic           acin, asub, ac, ah, av, lc, lv;
  logic           use_arith, chain, wr;
  logic           fc, fv, fn, fz;
  logic [FLW-1:0] mask, flags;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ax = a_i; ay = b_i; acin = 1'b0; asub = 1'b0;
    use_arith = 1'b1; chain = 1'b0; wr = 1'b1; mask = M_ALL;
    case (op)
      OP_ADD: ;
      OP_ADC: acin = c_i;
      OP_SUB: asub = 1'b1;
      OP_SBC: begin asub = 1'b1; acin = c_i; chain = 1'b1; end
      OP_CMP: begin asub = 1'b1; wr = 1'b0; end
      OP_CPC: begin asub = 1'b1; acin = c_i; chain = 1'b1; wr = 1'b0; end
      OP_NEG: begin ax = '0; ay = a_i; asub = 1'b1; end
      OP_INC: begin ay = W'(1); mask = M_SVNZ; end
      OP_DEC: begin ay = W'(1); asub = 1'b1; mask = M_SVNZ; end
      OP_LSL: ay = a_i;
      OP_ROL: begin ay = a_i; acin = c_i; end
      OP_AND, OP_OR, OP_XOR: begin use_arith = 1'b0; mask = M_SVNZ; end
      OP_COM, OP_LSR, OP_ROR, OP_ASR: begin use_arith = 1'b0; mask = M_SVNZC; end
      OP_SWP: begin use_arith = 1'b0; mask = '0; end
      default: begin use_arith = 1'b0; mask = '0; wr = 1'b0; end
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(ax), .y(ay), .cin(acin), .sub(asub),
    .r(ar), .c(ac), .h(ah), .v(av)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op(op), .a(a_i), .b(b_i), .cin(c_i),
    .r(lr), .c(lc), .v(lv)
  );

  always_comb begin
    r  = use_arith ? ar : lr;
    fc = use_arith ? ac : lc;
    fv = use_arith ? av : lv;
    fn = r[W-1];
    fz = (r == '0) & (~chain | z_i);
    flags = '0;
    flags[FH] = ah;
    flags[FS] = fn ^ fv;
    flags[FV] = fv;
    flags[FN] = fn;
    flags[FZ] = fz;
    flags[FC] = fc;
    flags = flags & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      upd_o   <= '0;
      wr_o    <= 1'b0;
    end else begin
      res_o   <= r;
      flags_o <= flags;
      upd_o   <= mask;
      wr_o    <= wr;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           z_i,
  input logic [W-1:0]   res_o,
  input logic [FLW-1:0] flags_o,
  input logic [FLW-1:0] upd_o,
  input logic           wr_o
);
  localparam int HW = W / 2;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (res_o == '0 && upd_o == '0 && flags_o == '0 && !wr_o));

  // R12
  mask_gates_flags_chk: assert property (@(posedge clk) disable iff (rst) (flags_o & ~upd_o) == '0);

  // R4
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP || op_i == OP_CPC) |=> !wr_o);

  // R5
  chain_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_SBC || op_i == OP_CPC) && !z_i) |=> !flags_o[FZ]);

  // R6
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> (!flags_o[FV] && upd_o == M_SVNZ));

  // R11
  swap_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SWP) |=> (upd_o == '0 && res_o == {$past(a_i[HW-1:0]), $past(a_i[W-1:HW])}));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> ({flags_o[FC], res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R13
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i > 5'd18) |=> (!wr_o && upd_o == '0 && res_o == '0));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       c_i = 1'b0, z_i = 1'b0;
  logic [7:0] res_o;
  logic [5:0] flags_o, upd_o;
  logic       wr_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .c_i(c_i), .z_i(z_i), .res_o(res_o), .flags_o(flags_o),
    .upd_o(upd_o), .wr_o(wr_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R2";
      2, 3, 10: return "R3";
      4, 5: return "R4";
      6, 7, 8: return "R6";
      9: return "R7";
      11, 12: return "R8";
      13, 14: return "R9";
      15, 16, 17: return "R10";
      18: return "R11";
      default: return "R13";
    endcase
  endfunction

  // {wr, mask[5:0], flags[5:0], result[7:0]}
  function automatic logic [20:0] model(input int op, input int a, input int b, input int c, input int z);
    int r = 0, ci = 0, x = a, y = b;
    logic fh = 0, fv = 0, fc = 0, wr = 1, chain = 0, n, zz, s;
    logic [5:0] m = 6'h3F, f;
    case (op)
      0, 1, 13, 14: begin
        if (op >= 13) y = a;
        ci = (op == 1 || op == 14) ? c : 0;
        r = (x + y + ci) & 255;
        fc = (x + y + ci) > 255;
        fh = ((x & 15) + (y & 15) + ci) > 15;
        fv = (x[7] == y[7]) && (r[7] != x[7]);
      end
      2, 3, 4, 5, 10: begin
        if (op == 10) begin x = 0; y = a; end
        ci = (op == 3 || op == 5) ? c : 0;
        chain = (op == 3 || op == 5);
        wr = !(op == 4 || op == 5);
        r = (x - y - ci) & 255;
        fc = x < y + ci;
        fh = (x & 15) < (y & 15) + ci;
        fv = (x[7] != y[7]) && (r[7] != x[7]);
      end
      6: begin r = a & b; m = 6'h1E; end
      7: begin r = a | b; m = 6'h1E; end
      8: begin r = a ^ b; m = 6'h1E; end
      9: begin r = 255 - a; fc = 1; m = 6'h1F; end
      11: begin r = (a + 1) & 255; fv = (a == 127); m = 6'h1E; end
      12: begin r = (a + 255) & 255; fv = (a == 128); m = 6'h1E; end
      15, 16, 17: begin
        r = a >> 1;
        if (op == 16) r = r + c * 128;
        if (op == 17) r = r + (a & 128);
        fc = a[0];
        fv = r[7] ^ fc;
        m = 6'h1F;
      end
      18: begin r = ((a & 15) << 4) | (a >> 4); m = 6'h00; end
      default: begin r = 0; m = 6'h00; wr = 0; end
    endcase
    n = r[7];
    zz = (r == 0) && (!chain || z != 0);
    s = n ^ fv;
    f = {fh, s, fv, n, zz, fc} & m;
    return {wr, m, f, r[7:0]};
  endfunction

  task automatic run(input int op, input int a, input int b, input int c, input int z);
    logic [20:0] exp, got;
    op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; c_i = c[0]; z_i = z[0];
    exp = model(op, a, b, c, z);
    @(negedge clk);
    got = {wr_o, upd_o, flags_o, res_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d z=%0d: actual wr/mask/flags/res=%h expected=%h",
               tag_of(op), op, a, b, c, z, got, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({wr_o, upd_o, flags_o, res_o} !== 21'd0) begin
      fails++;
      $display("FAIL R1 reset: actual=%h expected=0", {wr_o, upd_o, flags_o, res_o});
    end
    rst = 1'b0;
    // R2 half carry, overflow, carry out
    run(0, 8'h0F, 8'h01, 0, 0);
    run(0, 8'h7F, 8'h01, 0, 0);
    run(1, 8'hFF, 8'h00, 1, 0);
    // R3 borrow, negate of 0 and 0x80
    run(2, 8'h10, 8'h01, 0, 0);
    run(3, 8'h00, 8'h00, 1, 1);
    run(10, 8'h00, 8'h00, 0, 0);
    run(10, 8'h80, 8'h00, 0, 0);
    // R4 / R5 compare chain
    run(4, 8'h55, 8'h55, 0, 0);
    run(5, 8'h12, 8'h12, 0, 1);
    run(5, 8'h12, 8'h12, 0, 0);
    run(3, 8'h01, 8'h00, 1, 0);
    // R6, R7, R8 edges
    run(8, 8'hAA, 8'hAA, 1, 1);
    run(9, 8'h00, 8'h00, 0, 0);
    run(11, 8'h7F, 8'h00, 0, 0);
    run(12, 8'h80, 8'h00, 0, 0);
    run(12, 8'h01, 8'h00, 1, 0);
    // R9, R10 shifts and rotates
    run(13, 8'h88, 8'h00, 0, 0);
    run(14, 8'h40, 8'h00, 1, 0);
    run(16, 8'h01, 8'h00, 1, 0);
    run(17, 8'h81, 8'h00, 0, 0);
    run(15, 8'h01, 8'h00, 1, 0);
    // R11 swap, R13 unused code
    run(18, 8'h3C, 8'h00, 1, 1);
    run(25, 8'hFF, 8'hFF, 1, 1);
    // R12 and all ops: random mix
    for (int i = 0; i < 600; i++)
      run($urandom_range(0, 23), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 1), $urandom_range(0, 1));
    // R1: reset mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if ({wr_o, upd_o, flags_o, res_o} !== 21'd0) begin
      fails++;
      $display("FAIL R1 re-reset: actual=%h expected=0", {wr_o, upd_o, flags_o, res_o});
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule